// File: doc/BRIEF.md
# In-Order Instruction Dispatch Stage

This block is the decode and dispatch step between a fetch stage and three typed issue queues (floating-point, vector and general integer). Fetch writes up to four instructions per cycle into a twelve-entry in-order instruction queue. Each cycle the stage looks at the three oldest queue slots and sends as many as it can, oldest first, to the issue queues. A slot goes only if it is the oldest remaining slot, or every older slot went this same cycle. It also needs a free completion-queue slot, room and per-cycle acceptance in its issue queue, and a free rename buffer when it writes a destination register.

Each instruction word is `{tag, class[1:0], has_dest}`. Bit 0 is the destination flag, bits 2:1 are the class, and the upper bits are an opaque tag that passes through unchanged. The surrounding pipeline gives the free counts for each issue queue, the completion queue and each rename class. It reads the per-slot dispatch strobes and words in the same cycle and updates its own counters from them. A flush input empties the queue.

Top module: `insn_dispatch`

## Requirements
- R1: After reset the queue is empty: `disp_valid` is 0 and `fetch_ready` is 1.
- R2: With `fetch_ready`=1 and `flush`=0, the first `fetch_cnt` lanes of `fetch_insn` (lane 0 oldest, lane k at bits k*W+W-1:k*W) join the queue behind the existing entries. They can dispatch from the next cycle on, not in the cycle they are fetched.
- R3: `fetch_ready` is 1 exactly when the queue holds at most 8 of its 12 entries. A fetch offered while `fetch_ready`=0 is dropped, and the queue never holds more than 12.
- R4: Only the three oldest entries can dispatch. `disp_valid[i]` marks queue slot i, and `disp_insn` slot i carries that slot's word unchanged.
- R5: Dispatch is in order. `disp_valid` is always of the form 000, 001, 011 or 111, and a slot that is blocked stops every younger slot.
- R6: Class 1 (floating-point) dispatches at most min(1, `fiq_free`) per cycle. Class 2 (vector) dispatches at most min(2, `viq_free`). Class 0 (general) dispatches at most min(3, `giq_free`).
- R7: The number of dispatched slots never exceeds `cq_free`. Class 3 uses only a completion slot and ignores all issue-queue free counts.
- R8: An instruction of class 0, 1 or 2 with `has_dest`=1 needs a free rename buffer of its class (`gpr_free`, `fpr_free`, `vr_free`, counted per cycle). Without `has_dest`, or for class 3, the rename counts are ignored.
- R9: While `flush`=1 nothing dispatches and that cycle's fetch is dropped. In the next cycle the queue is empty.
- R10: Dispatched entries leave the queue at the clock edge. The oldest entry not dispatched becomes slot 0 in the next cycle, and the order of the rest is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and blocks dispatch this cycle |
| fetch_cnt | input | 3 | Number of valid fetch lanes, from lane 0 |
| fetch_insn | input | 36 | Four fetched instruction words, 9 bits each |
| fetch_ready | output | 1 | Queue can take a full fetch group |
| fiq_free | input | 2 | Free floating-point issue-queue entries |
| viq_free | input | 3 | Free vector issue-queue entries |
| giq_free | input | 3 | Free general issue-queue entries |
| cq_free | input | 5 | Free completion-queue entries |
| gpr_free | input | 5 | Free general rename buffers |
| fpr_free | input | 5 | Free floating-point rename buffers |
| vr_free | input | 5 | Free vector rename buffers |
| disp_valid | output | 3 | Per-slot dispatch strobe, bit i for queue slot i |
| disp_insn | output | 27 | Words of queue slots 0 to 2, 9 bits each |

## Verification
The dispatch decision is combinational from the queue contents and the free counts. The bench therefore changes the counts right after a falling edge and reads `disp_valid` and `disp_insn` 1 ns later, before the rising edge, in the same cycle. A fetched group or the effect of a flush can only be seen one rising edge later, so each of those checks is placed in the cycle after the stimulus. The checks made in the stimulus cycle itself confirm that nothing shows early. The table-driven scenarios always load the queue with the completion count at zero, so that every result comes from the one cycle in which the free counts are applied.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

   // Class field of an instruction word, bits [2:1]
   typedef enum logic [1:0] {
      CLS_GEN  = 2'd0,
      CLS_FP   = 2'd1,
      CLS_VEC  = 2'd2,
      CLS_NONE = 2'd3
   } insn_cls_e;

   // Field positions inside an instruction word
   localparam int DEST_BIT = 0;
   localparam int CLS_LSB  = 1;
   localparam int INFO_W   = 3;   // has_dest + class

endpackage

// File: rtl/iq_buffer.sv
module iq_buffer #(
   parameter int DEPTH         = 12,
   parameter int FETCH_W       = 4,
   parameter int DISP_W        = 3,
   parameter int W             = 9,
   parameter bit CLEAR_PAYLOAD = 1'b0,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int FW = $clog2(FETCH_W + 1),
   localparam int PW = $clog2(DISP_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic [PW-1:0]       pop_cnt,
   input  logic [FW-1:0]       push_cnt,
   input  logic [FETCH_W*W-1:0] push_data,
   output logic [DISP_W*W-1:0] head_data,
   output logic [CW-1:0]       count
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW = (FETCH_W > 1) ? $clog2(FETCH_W) : 1;

   logic [W-1:0]  ent  [DEPTH];
   logic [W-1:0]  nxt  [DEPTH];
   logic [W-1:0]  lane [FETCH_W];
   logic [CW-1:0] cnt_nxt;

   for (genvar k = 0; k < FETCH_W; k++) begin : g_lane
      assign lane[k] = push_data[k*W +: W];
   end

   for (genvar i = 0; i < DISP_W; i++) begin : g_head
      assign head_data[i*W +: W] = ent[i];
   end

   // Shift out popped entries, append pushed lanes behind the survivors
   always_comb begin
      int keep;
      keep = int'(count) - int'(pop_cnt);
      for (int j = 0; j < DEPTH; j++) begin
         int src;
         int k;
         src    = j + int'(pop_cnt);
         k      = j - keep;
         nxt[j] = ent[j];
         if (src < int'(count)) begin
            nxt[j] = ent[IW'(src)];
         end else if (k >= 0 && k < int'(push_cnt)) begin
            nxt[j] = lane[LW'(k)];
         end
      end
      cnt_nxt = clear ? '0 : CW'(keep + int'(push_cnt));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= cnt_nxt;
   end

   if (CLEAR_PAYLOAD) begin : g_pay_rst
      always_ff @(posedge clk) begin
         for (int j = 0; j < DEPTH; j++) begin
            if (!rst_n) ent[j] <= '0;
            else        ent[j] <= nxt[j];
         end
      end
   end else begin : g_pay_free
      always_ff @(posedge clk) begin
         for (int j = 0; j < DEPTH; j++) ent[j] <= nxt[j];
      end
   end

   // R3: occupancy bound
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);
   // R9: flush empties the queue by the next cycle
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);
   // R4: never remove more than is held
   p_pop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_cnt) <= int'(count));

endmodule

// File: rtl/dispatch_select.sv
module dispatch_select
   import dispatch_pkg::*;
#(
   parameter int DISP_W    = 3,
   parameter int IQ_DEPTH  = 12,
   parameter int FIQ_DEPTH = 2,
   parameter int VIQ_DEPTH = 4,
   parameter int GIQ_DEPTH = 6,
   parameter int FIQ_LIM   = 1,
   parameter int VIQ_LIM   = 2,
   parameter int GIQ_LIM   = 3,
   parameter int CQ_DEPTH  = 16,
   parameter int REN_DEPTH = 16,
   localparam int CW  = $clog2(IQ_DEPTH + 1),
   localparam int FQW = $clog2(FIQ_DEPTH + 1),
   localparam int VQW = $clog2(VIQ_DEPTH + 1),
   localparam int GQW = $clog2(GIQ_DEPTH + 1),
   localparam int CQW = $clog2(CQ_DEPTH + 1),
   localparam int RW  = $clog2(REN_DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [CW-1:0]            avail,
   input  logic [DISP_W*INFO_W-1:0] info,
   input  logic [FQW-1:0]           fiq_free,
   input  logic [VQW-1:0]           viq_free,
   input  logic [GQW-1:0]           giq_free,
   input  logic [CQW-1:0]           cq_free,
   input  logic [RW-1:0]            gpr_free,
   input  logic [RW-1:0]            fpr_free,
   input  logic [RW-1:0]            vr_free,
   output logic [DISP_W-1:0]        disp_valid
);
   insn_cls_e  cls  [DISP_W];
   logic       dst  [DISP_W];

   for (genvar i = 0; i < DISP_W; i++) begin : g_slot
      assign cls[i] = insn_cls_e'(info[i*INFO_W + CLS_LSB +: 2]);
      assign dst[i] = info[i*INFO_W + DEST_BIT];
   end

   // Oldest-first chain: each slot consumes resources left by older slots
   always_comb begin
      int  n_cq, n_f, n_v, n_g, r_g, r_f, r_v;
      logic go, ok;
      n_cq = 0; n_f = 0; n_v = 0; n_g = 0;
      r_g  = 0; r_f = 0; r_v = 0;
      go   = !flush;
      for (int i = 0; i < DISP_W; i++) begin
         ok = go && (i < int'(avail)) && (n_cq < int'(cq_free));
         unique case (cls[i])
            CLS_GEN: ok = ok && (n_g < GIQ_LIM) && (n_g < int'(giq_free))
                          && (!dst[i] || (r_g < int'(gpr_free)));
            CLS_FP:  ok = ok && (n_f < FIQ_LIM) && (n_f < int'(fiq_free))
                          && (!dst[i] || (r_f < int'(fpr_free)));
            CLS_VEC: ok = ok && (n_v < VIQ_LIM) && (n_v < int'(viq_free))
                          && (!dst[i] || (r_v < int'(vr_free)));
            default: ;
         endcase
         if (ok) begin
            n_cq++;
            unique case (cls[i])
               CLS_GEN: begin n_g++; if (dst[i]) r_g++; end
               CLS_FP:  begin n_f++; if (dst[i]) r_f++; end
               CLS_VEC: begin n_v++; if (dst[i]) r_v++; end
               default: ;
            endcase
         end
         disp_valid[i] = ok;
         go            = ok;
      end
   end

   // Observed per-class totals of what actually left, for the checks below
   int taken_f, taken_v, taken_g, taken_rg;
   always_comb begin
      taken_f = 0; taken_v = 0; taken_g = 0; taken_rg = 0;
      for (int i = 0; i < DISP_W; i++) begin
         if (disp_valid[i] && cls[i] == CLS_FP)  taken_f++;
         if (disp_valid[i] && cls[i] == CLS_VEC) taken_v++;
         if (disp_valid[i] && cls[i] == CLS_GEN) taken_g++;
         if (disp_valid[i] && cls[i] == CLS_GEN && dst[i]) taken_rg++;
      end
   end

   // R5: strobes form a run from slot 0
   p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((disp_valid + 1'b1) & disp_valid) == '0);
   // R9: nothing leaves during a flush
   p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> disp_valid == '0);
   // R7: completion space bounds the group
   p_cq_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(disp_valid) <= int'(cq_free));
   // R6: per-queue acceptance and room
   p_iq_caps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      taken_f <= FIQ_LIM && taken_f <= int'(fiq_free) &&
      taken_v <= VIQ_LIM && taken_v <= int'(viq_free) &&
      taken_g <= GIQ_LIM && taken_g <= int'(giq_free));
   // R8: general rename buffers never oversubscribed
   p_gpr_rename_r8: assert property (@(posedge clk) disable iff (!rst_n)
      taken_rg <= int'(gpr_free));

endmodule

// File: rtl/insn_dispatch.sv
module insn_dispatch
   import dispatch_pkg::*;
#(
   parameter int TAG_W     = 6,
   parameter int IQ_DEPTH  = 12,
   parameter int FETCH_W   = 4,
   parameter int DISP_W    = 3,
   parameter int FIQ_DEPTH = 2,
   parameter int VIQ_DEPTH = 4,
   parameter int GIQ_DEPTH = 6,
   parameter int FIQ_LIM   = 1,
   parameter int VIQ_LIM   = 2,
   parameter int GIQ_LIM   = 3,
   parameter int CQ_DEPTH  = 16,
   parameter int REN_DEPTH = 16,
   parameter bit CLEAR_PAYLOAD = 1'b0,
   localparam int W   = TAG_W + INFO_W,
   localparam int CW  = $clog2(IQ_DEPTH + 1),
   localparam int FW  = $clog2(FETCH_W + 1),
   localparam int PW  = $clog2(DISP_W + 1),
   localparam int FQW = $clog2(FIQ_DEPTH + 1),
   localparam int VQW = $clog2(VIQ_DEPTH + 1),
   localparam int GQW = $clog2(GIQ_DEPTH + 1),
   localparam int CQW = $clog2(CQ_DEPTH + 1),
   localparam int RW  = $clog2(REN_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [FW-1:0]         fetch_cnt,
   input  logic [FETCH_W*W-1:0]  fetch_insn,
   output logic                  fetch_ready,
   input  logic [FQW-1:0]        fiq_free,
   input  logic [VQW-1:0]        viq_free,
   input  logic [GQW-1:0]        giq_free,
   input  logic [CQW-1:0]        cq_free,
   input  logic [RW-1:0]         gpr_free,
   input  logic [RW-1:0]         fpr_free,
   input  logic [RW-1:0]         vr_free,
   output logic [DISP_W-1:0]     disp_valid,
   output logic [DISP_W*W-1:0]   disp_insn
);
   localparam logic [CW-1:0] READY_MAX = CW'(IQ_DEPTH - FETCH_W);

   if (DISP_W > IQ_DEPTH || FETCH_W > IQ_DEPTH || DISP_W < 1 || FETCH_W < 1)
   begin : g_bad_width
      $error("dispatch or fetch width does not fit the instruction queue");
   end
   if (FIQ_LIM > DISP_W || VIQ_LIM > DISP_W || GIQ_LIM > DISP_W)
   begin : g_bad_lim
      $error("issue-queue acceptance limit exceeds dispatch width");
   end
   if (FIQ_LIM > FIQ_DEPTH || VIQ_LIM > VIQ_DEPTH || GIQ_LIM > GIQ_DEPTH)
   begin : g_bad_depth
      $error("issue-queue acceptance limit exceeds its depth");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("tag width must be at least one bit");
   end

   logic [CW-1:0]            count;
   logic [FW-1:0]            fc_clamp;
   logic [FW-1:0]            push_cnt;
   logic [PW-1:0]            pop_cnt;
   logic [DISP_W*INFO_W-1:0] info;

   assign fetch_ready = (count <= READY_MAX);
   assign fc_clamp    = (int'(fetch_cnt) > FETCH_W) ? FW'(FETCH_W) : fetch_cnt;
   assign push_cnt    = (fetch_ready && !flush) ? fc_clamp : '0;
   assign pop_cnt     = PW'($countones(disp_valid));

   for (genvar i = 0; i < DISP_W; i++) begin : g_info
      assign info[i*INFO_W +: INFO_W] = disp_insn[i*W +: INFO_W];
   end

   iq_buffer #(
      .DEPTH(IQ_DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W), .W(W),
      .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .pop_cnt(pop_cnt), .push_cnt(push_cnt), .push_data(fetch_insn),
      .head_data(disp_insn), .count(count)
   );

   dispatch_select #(
      .DISP_W(DISP_W), .IQ_DEPTH(IQ_DEPTH),
      .FIQ_DEPTH(FIQ_DEPTH), .VIQ_DEPTH(VIQ_DEPTH), .GIQ_DEPTH(GIQ_DEPTH),
      .FIQ_LIM(FIQ_LIM), .VIQ_LIM(VIQ_LIM), .GIQ_LIM(GIQ_LIM),
      .CQ_DEPTH(CQ_DEPTH), .REN_DEPTH(REN_DEPTH)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .flush(flush), .avail(count), .info(info),
      .fiq_free(fiq_free), .viq_free(viq_free), .giq_free(giq_free),
      .cq_free(cq_free), .gpr_free(gpr_free), .fpr_free(fpr_free),
      .vr_free(vr_free), .disp_valid(disp_valid)
   );

   // R3: a full-group fetch never lands while the queue is above the mark
   p_ready_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_ready |=> int'(count) <= int'($past(count)));
   // R1: empty queue dispatches nothing
   p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count == '0 |-> disp_valid == '0);

endmodule

// File: tb/sim_insn_dispatch.sv
`timescale 1ns/1ps
module sim_insn_dispatch;
   localparam int W = 9;
   localparam logic [1:0] CG = 2'd0, CF = 2'd1, CV = 2'd2, CN = 2'd3;

   typedef struct packed {
      logic [5:0] cls;   // {slot2, slot1, slot0}
      logic [2:0] dst;   // {slot2, slot1, slot0}
      logic [1:0] fq;
      logic [2:0] vq;
      logic [2:0] gq;
      logic [4:0] cq;
      logic [4:0] gr;
      logic [4:0] fr;
      logic [4:0] vr;
      logic [2:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{ {CG,CG,CG}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b111 }, // R4
      '{ {CG,CF,CF}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b001 }, // R6 fp limit, R5
      '{ {CV,CV,CV}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b011 }, // R6 vec limit
      '{ {CG,CV,CF}, 3'b000, 2'd0, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b000 }, // R6 fp room, R5
      '{ {CG,CG,CG}, 3'b000, 2'd2, 3'd4, 3'd2, 5'd16, 5'd16, 5'd16, 5'd16, 3'b011 }, // R6 gen room
      '{ {CN,CN,CN}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd2,  5'd16, 5'd16, 5'd16, 3'b011 }, // R7 cq
      '{ {CN,CN,CN}, 3'b000, 2'd0, 3'd0, 3'd0, 5'd3,  5'd16, 5'd16, 5'd16, 3'b111 }, // R7 no iq
      '{ {CG,CG,CG}, 3'b111, 2'd2, 3'd4, 3'd6, 5'd16, 5'd1,  5'd16, 5'd16, 3'b001 }, // R8 gpr
      '{ {CG,CG,CG}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd16, 5'd0,  5'd16, 5'd16, 3'b111 }, // R8 no dest
      '{ {CG,CF,CV}, 3'b111, 2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd0,  5'd1,  3'b001 }, // R8 fpr
      '{ {CV,CV,CG}, 3'b000, 2'd2, 3'd1, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b011 }, // R6 vec room
      '{ {CG,CG,CG}, 3'b000, 2'd2, 3'd4, 3'd6, 5'd0,  5'd16, 5'd16, 5'd16, 3'b000 }, // R7 cq empty
      '{ {CG,CN,CN}, 3'b011, 2'd2, 3'd4, 3'd6, 5'd16, 5'd0,  5'd0,  5'd0,  3'b111 }, // R8 class 3
      '{ {CV,CF,CG}, 3'b111, 2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16, 3'b111 }  // R4 mixed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [2:0]  fetch_cnt = '0;
   logic [35:0] fetch_insn = '0;
   logic        fetch_ready;
   logic [1:0]  fiq_free = '0;
   logic [2:0]  viq_free = '0;
   logic [2:0]  giq_free = '0;
   logic [4:0]  cq_free = '0;
   logic [4:0]  gpr_free = '0;
   logic [4:0]  fpr_free = '0;
   logic [4:0]  vr_free = '0;
   logic [2:0]  disp_valid;
   logic [26:0] disp_insn;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   insn_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fetch_cnt(fetch_cnt), .fetch_insn(fetch_insn), .fetch_ready(fetch_ready),
      .fiq_free(fiq_free), .viq_free(viq_free), .giq_free(giq_free),
      .cq_free(cq_free), .gpr_free(gpr_free), .fpr_free(fpr_free),
      .vr_free(vr_free), .disp_valid(disp_valid), .disp_insn(disp_insn)
   );

   function automatic logic [W-1:0] mk(input int tag, input logic [1:0] c, input logic d);
      return {6'(tag), c, d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic res(input logic [1:0] f, input logic [2:0] v, input logic [2:0] g,
                      input logic [4:0] c, input logic [4:0] rg, input logic [4:0] rf,
                      input logic [4:0] rv);
      fiq_free = f; viq_free = v; giq_free = g; cq_free = c;
      gpr_free = rg; fpr_free = rf; vr_free = rv;
   endtask

   task automatic plenty();
      res(2'd2, 3'd4, 3'd6, 5'd16, 5'd16, 5'd16, 5'd16);
   endtask

   task automatic cyc();
      @(negedge clk);
      flush = 1'b0; fetch_cnt = '0;
   endtask

   task automatic do_flush();
      cyc(); flush = 1'b1; res(0, 0, 0, 0, 0, 0, 0);
   endtask

   function automatic logic [W-1:0] slot(input int i);
      return disp_insn[i*W +: W];
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      plenty();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 disp_valid in reset", 32'(disp_valid), 0);
      chk("R1 fetch_ready in reset", 32'(fetch_ready), 1);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 disp_valid after reset", 32'(disp_valid), 0);
      chk("R1 fetch_ready after reset", 32'(fetch_ready), 1);

      // Table of scenarios: load three with no completion room, then apply counts
      for (int v = 0; v < NV; v++) begin
         do_flush();
         cyc();
         for (int i = 0; i < 3; i++)
            fetch_insn[i*W +: W] = mk(v*3 + i, VECS[v].cls[i*2 +: 2], VECS[v].dst[i]);
         fetch_cnt = 3'd3;
         cyc();
         res(VECS[v].fq, VECS[v].vq, VECS[v].gq, VECS[v].cq,
             VECS[v].gr, VECS[v].fr, VECS[v].vr);
         #1;
         chk($sformatf("R5 R6 R7 R8 vector %0d mask", v), 32'(disp_valid), 32'(VECS[v].exp));
         for (int i = 0; i < 3; i++)
            if (VECS[v].exp[i])
               chk($sformatf("R4 vector %0d slot %0d word", v, i), 32'(slot(i)),
                   32'(mk(v*3 + i, VECS[v].cls[i*2 +: 2], VECS[v].dst[i])));
      end

      // R2: fetched words dispatch from the next cycle
      do_flush();
      cyc(); plenty();
      fetch_insn[0 +: W] = mk(50, CG, 1'b0);
      fetch_insn[W +: W] = mk(51, CG, 1'b0);
      fetch_cnt = 3'd2;
      #1;
      chk("R2 not visible in fetch cycle", 32'(disp_valid), 0);
      cyc(); #1;
      chk("R2 visible next cycle", 32'(disp_valid), 32'b011);
      chk("R2 lane0 oldest", 32'(slot(0)), 32'(mk(50, CG, 1'b0)));
      chk("R2 lane1 next", 32'(slot(1)), 32'(mk(51, CG, 1'b0)));

      // R3 / R10: fill to 12, refused fetch, drain in order
      do_flush();
      for (int g = 0; g < 3; g++) begin
         cyc();
         #0.5;
         chk($sformatf("R3 ready at %0d held", g*4), 32'(fetch_ready), 1);
         for (int k = 0; k < 4; k++) fetch_insn[k*W +: W] = mk(g*4 + k, CG, 1'b0);
         fetch_cnt = 3'd4;
      end
      cyc();
      for (int k = 0; k < 4; k++) fetch_insn[k*W +: W] = mk(20 + k, CG, 1'b0);
      fetch_cnt = 3'd4;
      #1;
      chk("R3 not ready at 12", 32'(fetch_ready), 0);
      cyc(); #1;
      chk("R3 still not ready after refused fetch", 32'(fetch_ready), 0);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) cyc();
         plenty();
         #1;
         chk($sformatf("R10 drain %0d mask", k), 32'(disp_valid), 32'b111);
         chk($sformatf("R10 drain %0d slot0", k), 32'(slot(0)), 32'(mk(3*k, CG, 1'b0)));
         chk($sformatf("R10 drain %0d slot2", k), 32'(slot(2)), 32'(mk(3*k + 2, CG, 1'b0)));
         if (k == 1) chk("R3 not ready at 9", 32'(fetch_ready), 0);
         if (k == 2) chk("R3 ready at 6", 32'(fetch_ready), 1);
      end
      cyc(); plenty(); #1;
      chk("R3 refused fetch left no entries", 32'(disp_valid), 0);

      // R10: partial dispatch keeps order
      do_flush();
      cyc();
      fetch_insn[0 +: W]   = mk(30, CF, 1'b0);
      fetch_insn[W +: W]   = mk(31, CF, 1'b0);
      fetch_insn[2*W +: W] = mk(32, CF, 1'b0);
      fetch_insn[3*W +: W] = mk(33, CG, 1'b0);
      fetch_cnt = 3'd4;
      cyc(); plenty(); #1;
      chk("R10 step a mask", 32'(disp_valid), 32'b001);
      chk("R10 step a slot0", 32'(slot(0)), 32'(mk(30, CF, 1'b0)));
      cyc(); plenty(); #1;
      chk("R10 step b mask", 32'(disp_valid), 32'b001);
      chk("R10 step b slot0", 32'(slot(0)), 32'(mk(31, CF, 1'b0)));
      cyc(); plenty(); #1;
      chk("R10 step c mask", 32'(disp_valid), 32'b011);
      chk("R10 step c slot1", 32'(slot(1)), 32'(mk(33, CG, 1'b0)));
      cyc(); plenty(); #1;
      chk("R10 step d empty", 32'(disp_valid), 0);

      // R9: flush blocks dispatch, drops fetch, empties queue
      do_flush();
      cyc();
      for (int k = 0; k < 3; k++) fetch_insn[k*W +: W] = mk(40 + k, CG, 1'b0);
      fetch_cnt = 3'd3;
      cyc(); plenty(); flush = 1'b1;
      fetch_insn[0 +: W] = mk(43, CG, 1'b0);
      fetch_insn[W +: W] = mk(44, CG, 1'b0);
      fetch_cnt = 3'd2;
      #1;
      chk("R9 no dispatch during flush", 32'(disp_valid), 0);
      cyc(); plenty(); #1;
      chk("R9 queue empty after flush", 32'(disp_valid), 0);
      chk("R9 ready after flush", 32'(fetch_ready), 1);

      finish_run();
   end
endmodule